// File: doc/BRIEF.md
# Dual-Tuning Quad-Offset Sine Synthesizer Core

This block is the digital half of a direct digital synthesizer. Every master clock cycle a 32-bit phase accumulator adds a tuning word, the top 12 bits of the accumulated phase are offset by a phase word, and the resulting angle is turned into a 10-bit offset-binary sine sample. The output frequency is the tuning word divided by 2^32, times the clock frequency.

Two tuning words and four phase words are held at the inputs. A 1-bit frequency select and a 2-bit phase select choose among them, and they can be switched from one sample to the next. Frequency-shift and phase-shift keying therefore need no register reload. The selects come either from dedicated pins or from control bits, and a source-select input decides which. The result passes through a clocked selection stage. A power-down input freezes the phase and parks the output at mid-scale.

Top module: `dds_core`

## Requirements
- R1: While `rst_n` is low, `sample` reads 512, the accumulator is zero and both select registers are zero. With tuning word 0x40000000 applied from reset, the first two samples after release are 512 and then 1023.
- R2: In every clock without power-down, the accumulator adds the selected tuning word modulo 2^32.
- R3: A registered frequency select of 0 picks `freq_word0` and a value of 1 picks `freq_word1`.
- R4: The registered 2-bit phase select picks `phase_word0`..`phase_word3` by value 0..3. The chosen 12-bit word is added modulo 4096 to accumulator bits 31:20 to form the angle.
- R5: When `sel_src_pins` is 1, the selects come from `fsel_pin`/`psel_pin`. When it is 0, they come from `fsel_bit`/`psel_bits`.
- R6: The selects are captured on a rising clock edge, so they act one cycle later. A select change applied before edge N alters the sample produced at edge N+1, not the one produced at edge N.
- R7: For angle p (0..4095), let s = sin(2*pi*(p+0.5)/4096). The sample is 512+round(511*s) when s is 0 or more, and 511-round(-511*s) when s is negative. The sample is registered, so a new value appears at every clock edge and is taken from the angle before that edge.
- R8: While `pwr_down` is high, each clock edge loads 512 into `sample` and the accumulator keeps its value. After release, the phase sequence resumes from the held value.
- R9: Tuning word 0x5671C71C gives about 0.3377 output periods per clock: 2.11 MHz at a 6.25 MHz clock, and about 1000 periods in 2962 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Hold accumulator, force mid-scale output |
| sel_src_pins | input | 1 | 1: selects from pins, 0: from control bits |
| fsel_pin | input | 1 | Frequency select pin |
| psel_pin | input | 2 | Phase select pins |
| fsel_bit | input | 1 | Frequency select control bit |
| psel_bits | input | 2 | Phase select control bits |
| freq_word0 | input | 32 | Tuning word 0 |
| freq_word1 | input | 32 | Tuning word 1 |
| phase_word0 | input | 12 | Phase offset 0 |
| phase_word1 | input | 12 | Phase offset 1 |
| phase_word2 | input | 12 | Phase offset 2 |
| phase_word3 | input | 12 | Phase offset 3 |
| sample | output | 10 | Offset-binary sine sample |

## Verification
The hardest case to reach from the ports is the one-cycle gap between a select change and its effect on the output. The sample depends on both the running accumulator and the select register, so a wrong latency hides among ordinary phase motion. The bench resets with both tuning words at zero, so the angle comes only from the phase words. It then switches a phase pin between two offsets whose sine values are known exactly, mid-scale and full-scale, and checks the sample on each of the two following edges. Power-down resumption is handled the same way: a quarter-turn tuning word makes the held phase visible as a fixed four-value cycle.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam int NUM_FREQ = 2;
  localparam int NUM_PH   = 4;
  localparam real PI_R    = 3.14159265358979323846;

  // Rounded magnitude of one quarter-wave entry, sampled at bin centres
  function automatic int quarter_mag(int idx, int phase_w, int amp);
    real ang;
    ang = 2.0 * PI_R * (real'(idx) + 0.5) / real'(1 << phase_w);
    return int'(real'(amp) * $sin(ang));
  endfunction

endpackage

// File: rtl/dds_sel_sync.sv
module dds_sel_sync #(
  parameter int FSEL_W = 1,
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_pins,
  input  logic [FSEL_W-1:0] fsel_pin,
  input  logic [PSEL_W-1:0] psel_pin,
  input  logic [FSEL_W-1:0] fsel_bit,
  input  logic [PSEL_W-1:0] psel_bits,
  output logic [FSEL_W-1:0] fsel_q,
  output logic [PSEL_W-1:0] psel_q
);

  logic [FSEL_W-1:0] fsel_d;
  logic [PSEL_W-1:0] psel_d;

  always_comb begin
    if (src_pins) begin
      fsel_d = fsel_pin;
      psel_d = psel_pin;
    end else begin
      fsel_d = fsel_bit;
      psel_d = psel_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q <= '0;
      psel_q <= '0;
    end else begin
      fsel_q <= fsel_d;
      psel_q <= psel_d;
    end
  end

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W    = 32,
  parameter int PHASE_W  = 12,
  parameter int NUM_FREQ = 2,
  parameter int NUM_PH   = 4,
  localparam int FSEL_W  = $clog2(NUM_FREQ),
  localparam int PSEL_W  = $clog2(NUM_PH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic [ACC_W-1:0]   tune_words [NUM_FREQ],
  input  logic [PHASE_W-1:0] ofs_words  [NUM_PH],
  input  logic [FSEL_W-1:0]  fsel,
  input  logic [PSEL_W-1:0]  psel,
  output logic [ACC_W-1:0]   acc_q,
  output logic [ACC_W-1:0]   step,
  output logic [PHASE_W-1:0] phase_addr
);

  logic             acc_en;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    step       = tune_words[fsel];
    acc_en     = !hold;
    acc_d      = acc_q + step;
    phase_addr = acc_q[ACC_W-1 -: PHASE_W] + ofs_words[psel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
  parameter int PHASE_W = 12,
  parameter int OUT_W   = 10,
  localparam int QA_W   = PHASE_W - 2,
  localparam int QDEPTH = 1 << QA_W,
  localparam int MAG_W  = OUT_W - 1,
  localparam int AMP    = (1 << MAG_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               force_mid,
  input  logic [PHASE_W-1:0] phase_addr,
  output logic [OUT_W-1:0]   sample
);

  localparam logic [OUT_W-1:0] MID    = OUT_W'(1 << MAG_W);
  localparam logic [OUT_W-1:0] MID_LO = OUT_W'((1 << MAG_W) - 1);

  logic [MAG_W-1:0] qtab [QDEPTH];

  for (genvar gi = 0; gi < QDEPTH; gi++) begin : g_qtab
    localparam int QV = dds_pkg::quarter_mag(gi, PHASE_W, AMP);
    assign qtab[gi] = MAG_W'(QV);
  end

  logic [1:0]       quad;
  logic [QA_W-1:0]  idx;
  logic [QA_W-1:0]  idx_m;
  logic [MAG_W-1:0] mag;
  logic [OUT_W-1:0] wave;
  logic [OUT_W-1:0] sample_d;

  always_comb begin
    quad  = phase_addr[PHASE_W-1 -: 2];
    idx   = phase_addr[QA_W-1:0];
    idx_m = quad[0] ? ~idx : idx;
    mag   = qtab[idx_m];
    if (quad[1]) begin
      wave = MID_LO - {1'b0, mag};
    end else begin
      wave = MID + {1'b0, mag};
    end
    sample_d = force_mid ? MID : wave;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample <= MID;
    end else begin
      sample <= sample_d;
    end
  end

endmodule

// File: rtl/dds_core.sv
module dds_core #(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 12,
  parameter int OUT_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_down,
  input  logic               sel_src_pins,
  input  logic               fsel_pin,
  input  logic [1:0]         psel_pin,
  input  logic               fsel_bit,
  input  logic [1:0]         psel_bits,
  input  logic [ACC_W-1:0]   freq_word0,
  input  logic [ACC_W-1:0]   freq_word1,
  input  logic [PHASE_W-1:0] phase_word0,
  input  logic [PHASE_W-1:0] phase_word1,
  input  logic [PHASE_W-1:0] phase_word2,
  input  logic [PHASE_W-1:0] phase_word3,
  output logic [OUT_W-1:0]   sample
);

  localparam int NF     = dds_pkg::NUM_FREQ;
  localparam int NP     = dds_pkg::NUM_PH;
  localparam int FSEL_W = $clog2(NF);
  localparam int PSEL_W = $clog2(NP);

  logic [ACC_W-1:0]   tune_words [NF];
  logic [PHASE_W-1:0] ofs_words  [NP];
  logic [FSEL_W-1:0]  fsel_q;
  logic [PSEL_W-1:0]  psel_q;
  logic [ACC_W-1:0]   acc_val;
  logic [ACC_W-1:0]   step_val;
  logic [PHASE_W-1:0] phase_addr;

  always_comb begin
    tune_words[0] = freq_word0;
    tune_words[1] = freq_word1;
    ofs_words[0]  = phase_word0;
    ofs_words[1]  = phase_word1;
    ofs_words[2]  = phase_word2;
    ofs_words[3]  = phase_word3;
  end

  dds_sel_sync #(.FSEL_W(FSEL_W), .PSEL_W(PSEL_W)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pins  (sel_src_pins),
    .fsel_pin  (fsel_pin),
    .psel_pin  (psel_pin),
    .fsel_bit  (fsel_bit),
    .psel_bits (psel_bits),
    .fsel_q    (fsel_q),
    .psel_q    (psel_q)
  );

  dds_phase_acc #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .NUM_FREQ(NF), .NUM_PH(NP)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (pwr_down),
    .tune_words (tune_words),
    .ofs_words  (ofs_words),
    .fsel       (fsel_q),
    .psel       (psel_q),
    .acc_q      (acc_val),
    .step       (step_val),
    .phase_addr (phase_addr)
  );

  dds_sine_lut #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_lut (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_mid  (pwr_down),
    .phase_addr (phase_addr),
    .sample     (sample)
  );

endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk #(
  parameter int ACC_W = 32,
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_down,
  input logic             sel_src_pins,
  input logic             fsel_pin,
  input logic [1:0]       psel_pin,
  input logic             fsel_bit,
  input logic [1:0]       psel_bits,
  input logic             fsel_q,
  input logic [1:0]       psel_q,
  input logic [ACC_W-1:0] acc_val,
  input logic [ACC_W-1:0] step_val,
  input logic [OUT_W-1:0] sample
);

  localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W - 1));

  // R8: output parks at mid-scale after a power-down cycle
  a_r8_pd_midscale: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> sample == MID);

  // R8: accumulator frozen through power-down
  a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> acc_val == $past(acc_val));

  // R2: accumulator advances by the selected word
  a_r2_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_down |=> acc_val == $past(acc_val) + $past(step_val));

  // R5 / R6: pin source captured on the edge
  a_r5_pin_source: assert property (@(posedge clk) disable iff (!rst_n)
    sel_src_pins |=> (fsel_q == $past(fsel_pin)) && (psel_q == $past(psel_pin)));

  // R5 / R6: control-bit source captured on the edge
  a_r5_bit_source: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_src_pins |=> (fsel_q == $past(fsel_bit)) && (psel_q == $past(psel_bits)));

endmodule

bind dds_core dds_core_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_down     (pwr_down),
  .sel_src_pins (sel_src_pins),
  .fsel_pin     (fsel_pin),
  .psel_pin     (psel_pin),
  .fsel_bit     (fsel_bit),
  .psel_bits    (psel_bits),
  .fsel_q       (fsel_q),
  .psel_q       (psel_q),
  .acc_val      (acc_val),
  .step_val     (step_val),
  .sample       (sample)
);

// File: tb/test_dds_core.sv
module test_dds_core;

  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pwr_down;
  logic        sel_src_pins;
  logic        fsel_pin;
  logic [1:0]  psel_pin;
  logic        fsel_bit;
  logic [1:0]  psel_bits;
  logic [31:0] freq_word0, freq_word1;
  logic [11:0] phase_word0, phase_word1, phase_word2, phase_word3;
  logic [9:0]  sample;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dds_core i_dds_core (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .sel_src_pins(sel_src_pins),
    .fsel_pin(fsel_pin), .psel_pin(psel_pin), .fsel_bit(fsel_bit), .psel_bits(psel_bits),
    .freq_word0(freq_word0), .freq_word1(freq_word1),
    .phase_word0(phase_word0), .phase_word1(phase_word1),
    .phase_word2(phase_word2), .phase_word3(phase_word3),
    .sample(sample)
  );

  function automatic int ref_wave(int p);
    real s;
    s = $sin(2.0 * PI * (real'(p) + 0.5) / 4096.0);
    if (s >= 0.0) return 512 + int'(511.0 * s);
    else return 511 - int'(-511.0 * s);
  endfunction

  // Behavioural model built from R1..R8
  logic [31:0] m_acc;
  logic        m_fs;
  logic [1:0]  m_ps;
  int          m_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_fs = 0; m_ps = 0; m_out = 512;
    end else begin
      logic [31:0] tw;
      logic [11:0] po;
      tw = m_fs ? freq_word1 : freq_word0;
      case (m_ps)
        2'd0: po = phase_word0;
        2'd1: po = phase_word1;
        2'd2: po = phase_word2;
        default: po = phase_word3;
      endcase
      m_out = pwr_down ? 512 : ref_wave(int'(m_acc[31:20] + po));
      if (!pwr_down) m_acc = m_acc + tw;
      m_fs = sel_src_pins ? fsel_pin : fsel_bit;
      m_ps = sel_src_pins ? psel_pin : psel_bits;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
  endtask

  typedef struct packed {
    logic [31:0] fw0;
    logic [31:0] fw1;
    logic [11:0] p0, p1, p2, p3;
    logic        src;
    logic        fpin;
    logic [1:0]  ppin;
    logic        fbit;
    logic [1:0]  pbits;
    logic [15:0] ncyc;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0100_0000, 32'h0040_0000, 12'h000, 12'h400, 12'h800, 12'hC00, 1'b0, 1'b1, 2'd3, 1'b0, 2'd0, 16'd80},
    '{32'h0100_0000, 32'h0040_0000, 12'h000, 12'h400, 12'h800, 12'hC00, 1'b0, 1'b0, 2'd0, 1'b1, 2'd0, 16'd80},
    '{32'h0123_4567, 32'h0040_0000, 12'h000, 12'h400, 12'h800, 12'hC00, 1'b0, 1'b1, 2'd1, 1'b0, 2'd2, 16'd80},
    '{32'h0123_4567, 32'h0800_0000, 12'h000, 12'h155, 12'h800, 12'hFFF, 1'b0, 1'b0, 2'd0, 1'b1, 2'd3, 16'd80},
    '{32'h0123_4567, 32'h0800_0000, 12'h0A0, 12'h3FF, 12'h800, 12'h7FF, 1'b1, 1'b1, 2'd1, 1'b0, 2'd2, 16'd80},
    '{32'h0723_4567, 32'h0800_0000, 12'h0A0, 12'h3FF, 12'h801, 12'h7FF, 1'b1, 1'b0, 2'd3, 1'b1, 2'd0, 16'd80},
    '{32'hFFFF_FFFF, 32'hF000_0001, 12'h000, 12'h3FF, 12'h801, 12'h7FF, 1'b0, 1'b1, 2'd2, 1'b0, 2'd0, 16'd80},
    '{32'h5671_C71C, 32'hF000_0001, 12'h000, 12'h3FF, 12'h801, 12'h7FF, 1'b1, 1'b1, 2'd0, 1'b0, 2'd1, 16'd80}
  };

  localparam string VREQ [NV] = '{"R2 R3", "R3", "R4", "R4", "R5", "R5", "R2", "R7"};

  initial begin
    rst_n = 1'b0; pwr_down = 1'b0; sel_src_pins = 1'b0;
    fsel_pin = 1'b0; psel_pin = 2'd0; fsel_bit = 1'b0; psel_bits = 2'd0;
    freq_word0 = 32'h4000_0000; freq_word1 = 32'h0;
    phase_word0 = 12'h0; phase_word1 = 12'h0; phase_word2 = 12'h0; phase_word3 = 12'h0;
    @(negedge clk);
    tick();
    check("R1 reset sample", int'(sample), 512);
    rst_n = 1'b1;
    tick();
    check("R1 first sample", int'(sample), 512);
    tick();
    check("R1 accumulator from zero", int'(sample), 1023);

    // Table walk against the model
    for (int v = 0; v < NV; v++) begin
      int bad = 0;
      int fa = 0;
      int fe = 0;
      freq_word0 = VECS[v].fw0; freq_word1 = VECS[v].fw1;
      phase_word0 = VECS[v].p0; phase_word1 = VECS[v].p1;
      phase_word2 = VECS[v].p2; phase_word3 = VECS[v].p3;
      sel_src_pins = VECS[v].src; fsel_pin = VECS[v].fpin; psel_pin = VECS[v].ppin;
      fsel_bit = VECS[v].fbit; psel_bits = VECS[v].pbits;
      for (int c = 0; c < int'(VECS[v].ncyc); c++) begin
        tick();
        if (int'(sample) != m_out && bad == 0) begin
          fa = int'(sample); fe = m_out;
        end
        if (int'(sample) != m_out) bad++;
      end
      if (bad == 0) check(VREQ[v], 0, 0);
      else check(VREQ[v], fa, fe);
    end

    // R6: select latency, phase only from offsets
    freq_word0 = 0; freq_word1 = 0;
    phase_word0 = 12'h000; phase_word1 = 12'h400;
    sel_src_pins = 1'b1; fsel_pin = 1'b0; psel_pin = 2'd0;
    do_reset();
    repeat (3) tick();
    check("R6 baseline", int'(sample), 512);
    psel_pin = 2'd1;
    tick();
    check("R6 no effect on first edge", int'(sample), 512);
    tick();
    check("R6 effect on second edge", int'(sample), 1023);
    psel_pin = 2'd0;
    tick();
    check("R6 old offset still used", int'(sample), 1023);
    tick();
    check("R6 back to offset 0", int'(sample), 512);

    // R8: power-down hold and resume with quarter-turn steps
    freq_word0 = 32'h4000_0000; phase_word0 = 12'h000;
    sel_src_pins = 1'b0; fsel_bit = 1'b0; psel_bits = 2'd0;
    do_reset();
    tick();
    tick();
    check("R7 quarter turn peak", int'(sample), 1023);
    pwr_down = 1'b1;
    tick();
    check("R8 midscale in power-down", int'(sample), 512);
    tick();
    check("R8 midscale held", int'(sample), 512);
    pwr_down = 1'b0;
    tick();
    check("R8 resume from held phase", int'(sample), 511);
    tick();
    check("R7 trough", int'(sample), 0);

    // R9: output frequency for the example tuning word
    begin
      int rises = 0;
      int prev;
      freq_word0 = 32'h5671_C71C;
      do_reset();
      tick();
      prev = int'(sample);
      for (int c = 0; c < 2962; c++) begin
        tick();
        if (prev < 512 && int'(sample) >= 512) rises++;
        prev = int'(sample);
      end
      checks++;
      if (rises < 990 || rises > 1010) begin
        failures++;
        $display("FAIL R9 periods actual=%0d expected=1000", rises);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule